// File: doc/BRIEF.md
# Double-Buffered Phase Increment Oscillator Core

This block is the phase engine of a numerically controlled oscillator. It keeps a 20-bit phase accumulator that adds a programmable increment on every rising edge of the oscillator clock. The accumulator wraps modulo 2^20, and each carry out of its top bit produces a one-cycle overflow pulse. The output frequency is therefore proportional to the increment.

Software sets the increment one byte at a time through a byte-wide register port on the bus clock. The bytes are staged in three registers. The active increment, which is the copy the accumulator actually uses, is updated only when the low byte is written. That write snapshots all three staged bytes into a hold register and sends a toggle request into the oscillator clock domain. The oscillator clock may be asynchronous to the bus clock. The new value becomes active on a falling edge of the oscillator clock once the request has been synchronized. An acknowledge toggle returns to the bus side, so every commit is seen exactly once.

A low-byte write that arrives while an earlier commit is still in flight is remembered. When the acknowledge for the earlier commit comes back, the bytes staged at that moment are sent, so the newest assembled value always ends up active. The register port is plain control: each write and each read completes in one cycle, and no stream handshake is involved.

Top module: `nco_dbuf_top`

## Requirements
- R1: After reset, reads return 0x01 at the low address, 0x00 at the high address and 0x00 at the upper address. The accumulator then advances by 1 per oscillator clock.
- R2: The byte map is as follows. Address 0 is the low byte and holds increment bits 7:0. Address 1 is the high byte and holds bits 15:8. Address 2 is the upper byte and holds bits 19:16 in its bits 3:0. Address 3 reads 0x00.
- R3: Bits 7:4 of the upper byte always read as zero, whatever value was written to them.
- R4: Writes to the high or upper byte alone leave the active increment, and hence the accumulator step, unchanged.
- R5: A write to address 0 commits the 20-bit value {upper, high, low} to the active increment. The commit lands on a falling oscillator-clock edge after a synchronization delay of a few cycles.
- R6: On each rising oscillator-clock edge, the accumulator becomes (accumulator + active increment) mod 2^20.
- R7: The overflow output is high for exactly the oscillator cycle that follows an addition with a carry out of bit 19, and low otherwise.
- R8: If address 0 is written again while a commit is still pending, the value that finally becomes active is the most recently assembled one.
- R9: Reads return the staged bytes, not the active increment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Register port clock |
| bus_rst_n | input | 1 | Asynchronous active-low reset, bus domain |
| reg_wr | input | 1 | Write strobe, one byte per cycle |
| reg_addr | input | 2 | Byte address (0 low, 1 high, 2 upper) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| nco_clk | input | 1 | Oscillator clock |
| nco_rst_n | input | 1 | Asynchronous active-low reset, oscillator domain |
| phase_acc | output | 20 | Phase accumulator value |
| phase_ovf | output | 1 | One-cycle pulse after a carry out of bit 19 |

## Verification
The bench uses the default 20-bit increment width, so the whole increment range can be reached. That covers values near 2^20, where the overflow output fires on almost every cycle, as well as the reset value of 1. The bus clock runs at 125 MHz and the oscillator clock runs at an unrelated period. The request and acknowledge toggles therefore cross with phases that keep shifting. This makes it possible to land a second low-byte write while the first commit is still in flight.

// File: rtl/nco_dbuf_pkg.sv
package nco_dbuf_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_LO = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_HI = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_UP = 2'd2;
endpackage

// File: rtl/nco_dbuf_regs.sv
module nco_dbuf_regs
  import nco_dbuf_pkg::*;
#(
  parameter int INC_W = 20
) (
  input  logic              bus_clk,
  input  logic              bus_rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              ack_tgl,
  output logic              req_tgl,
  output logic [INC_W-1:0]  hold_inc
);
  localparam int UP_W = INC_W - 2*BYTE_W;
  localparam logic [INC_W-1:0] RST_INC = INC_W'(1);

  logic [BYTE_W-1:0] lo_q, hi_q;
  logic [UP_W-1:0]   up_q;
  logic              ack_s1, ack_s2, redo_q, pending, lo_wr;

  assign pending = req_tgl ^ ack_s2;
  assign lo_wr   = reg_wr && (reg_addr == ADDR_LO);

  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) begin
      ack_s1 <= 1'b0;
      ack_s2 <= 1'b0;
    end else begin
      ack_s1 <= ack_tgl;
      ack_s2 <= ack_s1;
    end
  end

  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) begin
      lo_q <= RST_INC[BYTE_W-1:0];
      hi_q <= RST_INC[2*BYTE_W-1:BYTE_W];
      up_q <= RST_INC[INC_W-1:2*BYTE_W];
    end else if (reg_wr) begin
      case (reg_addr)
        ADDR_LO: lo_q <= reg_wdata;
        ADDR_HI: hi_q <= reg_wdata;
        ADDR_UP: up_q <= reg_wdata[UP_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) begin
      hold_inc <= RST_INC;
      req_tgl  <= 1'b0;
      redo_q   <= 1'b0;
    end else if (!pending) begin
      if (lo_wr) begin
        hold_inc <= {up_q, hi_q, reg_wdata};
        req_tgl  <= ~req_tgl;
        redo_q   <= 1'b0;
      end else if (redo_q) begin
        hold_inc <= {up_q, hi_q, lo_q};
        req_tgl  <= ~req_tgl;
        redo_q   <= 1'b0;
      end
    end else if (lo_wr) begin
      redo_q <= 1'b1;
    end
  end

  always_comb begin
    case (reg_addr)
      ADDR_LO: reg_rdata = lo_q;
      ADDR_HI: reg_rdata = hi_q;
      ADDR_UP: reg_rdata = BYTE_W'(up_q);
      default: reg_rdata = '0;
    endcase
  end

  // R8: the snapshot must not move while the other domain may sample it
  a_r8_hold_frozen: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    pending |=> $stable(hold_inc));
  // R5: a new request is only raised when none is outstanding
  a_r5_single_request: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (req_tgl != $past(req_tgl)) |-> !$past(pending));
  // R3: upper nibble of the upper byte reads zero
  a_r3_upper_nibble_zero: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (reg_addr == ADDR_UP) |-> (reg_rdata[BYTE_W-1:UP_W] == '0));
endmodule

// File: rtl/nco_dbuf_xfer.sv
module nco_dbuf_xfer #(
  parameter int INC_W = 20
) (
  input  logic             nco_clk,
  input  logic             nco_rst_n,
  input  logic             req_tgl,
  input  logic [INC_W-1:0] hold_inc,
  output logic             ack_tgl,
  output logic [INC_W-1:0] active_inc
);
  localparam logic [INC_W-1:0] RST_INC = INC_W'(1);

  logic req_s1, req_s2, req_s3, take;

  assign take    = req_s2 ^ req_s3;
  assign ack_tgl = req_s3;

  always_ff @(negedge nco_clk or negedge nco_rst_n) begin
    if (!nco_rst_n) begin
      req_s1     <= 1'b0;
      req_s2     <= 1'b0;
      req_s3     <= 1'b0;
      active_inc <= RST_INC;
    end else begin
      req_s1 <= req_tgl;
      req_s2 <= req_s1;
      req_s3 <= req_s2;
      if (take) active_inc <= hold_inc;
    end
  end

  // R4: the active increment only moves on a synchronized commit
  a_r4_active_only_on_commit: assert property (@(negedge nco_clk) disable iff (!nco_rst_n)
    (active_inc != $past(active_inc)) |-> $past(take));
endmodule

// File: rtl/nco_dbuf_acc.sv
module nco_dbuf_acc #(
  parameter int INC_W = 20
) (
  input  logic             nco_clk,
  input  logic             nco_rst_n,
  input  logic [INC_W-1:0] active_inc,
  output logic [INC_W-1:0] phase_acc,
  output logic             phase_ovf
);
  logic [INC_W:0] sum;

  assign sum = {1'b0, phase_acc} + {1'b0, active_inc};

  always_ff @(posedge nco_clk or negedge nco_rst_n) begin
    if (!nco_rst_n) begin
      phase_acc <= '0;
      phase_ovf <= 1'b0;
    end else begin
      phase_acc <= sum[INC_W-1:0];
      phase_ovf <= sum[INC_W];
    end
  end

  // R7: an overflow pulse means the accumulator wrapped below its old value
  a_r7_ovf_means_wrap: assert property (@(posedge nco_clk) disable iff (!nco_rst_n)
    phase_ovf |-> (phase_acc < $past(phase_acc)));
  // R6: without overflow the accumulator never moves backwards
  a_r6_no_ovf_monotonic: assert property (@(posedge nco_clk) disable iff (!nco_rst_n)
    !phase_ovf |-> (phase_acc >= $past(phase_acc)));
endmodule

// File: rtl/nco_dbuf_top.sv
module nco_dbuf_top
  import nco_dbuf_pkg::*;
#(
  parameter int INC_W = 20
) (
  input  logic              bus_clk,
  input  logic              bus_rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              nco_clk,
  input  logic              nco_rst_n,
  output logic [INC_W-1:0]  phase_acc,
  output logic              phase_ovf
);
  logic             req_tgl, ack_tgl;
  logic [INC_W-1:0] hold_inc, active_inc;

  nco_dbuf_regs #(.INC_W(INC_W)) regs_i (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ack_tgl(ack_tgl), .req_tgl(req_tgl), .hold_inc(hold_inc)
  );

  nco_dbuf_xfer #(.INC_W(INC_W)) xfer_i (
    .nco_clk(nco_clk), .nco_rst_n(nco_rst_n), .req_tgl(req_tgl),
    .hold_inc(hold_inc), .ack_tgl(ack_tgl), .active_inc(active_inc)
  );

  nco_dbuf_acc #(.INC_W(INC_W)) acc_i (
    .nco_clk(nco_clk), .nco_rst_n(nco_rst_n), .active_inc(active_inc),
    .phase_acc(phase_acc), .phase_ovf(phase_ovf)
  );
endmodule

// File: tb/nco_dbuf_top_tb_top.sv
module nco_dbuf_top_tb_top;
  logic        bus_clk = 1'b0, nco_clk = 1'b0;
  logic        bus_rst_n = 1'b0, nco_rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [7:0]  reg_wdata = 8'd0;
  logic [7:0]  reg_rdata;
  logic [19:0] phase_acc;
  logic        phase_ovf;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #4 bus_clk = ~bus_clk;
  always #7.3 nco_clk = ~nco_clk;

  nco_dbuf_top dut_i (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .nco_clk(nco_clk), .nco_rst_n(nco_rst_n),
    .phase_acc(phase_acc), .phase_ovf(phase_ovf)
  );

  function automatic logic [19:0] exp_step(input logic [19:0] a0, input logic [19:0] inc);
    logic [20:0] s = {1'b0, a0} + {1'b0, inc};
    return s[19:0];
  endfunction

  function automatic logic exp_carry(input logic [19:0] a0, input logic [19:0] inc);
    logic [20:0] s = {1'b0, a0} + {1'b0, inc};
    return s[20];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge bus_clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge bus_clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_check(input string tag, input logic [1:0] a, input logic [7:0] exp);
    @(negedge bus_clk);
    reg_addr = a;
    #1;
    check(tag, {24'd0, reg_rdata}, {24'd0, exp});
  endtask

  task automatic write_inc(input logic [19:0] v);
    wr(2'd2, {4'd0, v[19:16]});
    wr(2'd1, v[15:8]);
    wr(2'd0, v[7:0]);
  endtask

  task automatic settle();
    repeat (20) @(negedge nco_clk);
  endtask

  // Samples at falling edges, between accumulator updates.
  task automatic measure(input string tag, input logic [19:0] inc, input int n);
    logic [19:0] a0, a1;
    @(negedge nco_clk);
    a0 = phase_acc;
    for (int i = 0; i < n; i++) begin
      @(negedge nco_clk);
      a1 = phase_acc;
      check({tag, " step"}, {12'd0, a1}, {12'd0, exp_step(a0, inc)});
      check({tag, " ovf"}, {31'd0, phase_ovf}, {31'd0, exp_carry(a0, inc)});
      a0 = a1;
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [19:0] v, cur;
    void'($urandom(32'h5eed_1234));
    repeat (5) @(negedge bus_clk);
    bus_rst_n = 1'b1; nco_rst_n = 1'b1;
    repeat (4) @(negedge nco_clk);

    // R1 reset state
    rd_check("R1 reset low", 2'd0, 8'h01);
    rd_check("R1 reset high", 2'd1, 8'h00);
    rd_check("R1 reset upper", 2'd2, 8'h00);
    measure("R1 reset inc", 20'h00001, 4);

    // R2 map, R3 upper nibble ignored
    wr(2'd2, 8'hFA);
    rd_check("R3 upper nibble", 2'd2, 8'h0A);
    rd_check("R2 addr3 zero", 2'd3, 8'h00);

    // R4 / R9: staged change without low write
    wr(2'd1, 8'h5C);
    settle();
    rd_check("R9 staged high", 2'd1, 8'h5C);
    measure("R4 no commit", 20'h00001, 4);
    wr(2'd0, 8'h07);
    settle();
    cur = 20'hA5C07;
    measure("R5 commit", cur, 4);

    // R7 near-full increment
    write_inc(20'hFFFFF);
    settle();
    measure("R7 full", 20'hFFFFF, 6);
    write_inc(20'h80000);
    settle();
    measure("R7 half", 20'h80000, 6);

    // R8 rewrite while pending
    write_inc(20'h12233);
    wr(2'd1, 8'h44);
    wr(2'd0, 8'h55);
    settle();
    rd_check("R8 low", 2'd0, 8'h55);
    measure("R8 latest", 20'h14455, 4);

    // R2 R5 R6 random increments
    for (int k = 0; k < 10; k++) begin
      v = 20'($urandom());
      write_inc(v);
      settle();
      rd_check("R2 rand low", 2'd0, v[7:0]);
      rd_check("R2 rand high", 2'd1, v[15:8]);
      rd_check("R2 rand upper", 2'd2, {4'd0, v[19:16]});
      measure("R6 rand", v, 6);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule